// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block is a synchronous memory core that behaves like a double-data-rate static RAM working in fixed bursts of four words. It runs on one clock per bus cycle. Each cycle carries two data beats, shown as two lanes: a first-half lane (the beat on the rising edge of the clock) and a second-half lane (the beat on the rising edge of the inverted clock). A host starts a transaction by pulling the load strobe low with a direction and a word address. The core then moves four words in two cycles. The two low address bits pick any starting word inside an aligned group of four, and the order wraps inside that group.

Write beats carry per-byte, active-low enables, so any byte of any beat can be left untouched. Read words come back on two output lanes with a fixed latency. Each lane has its own output enable, which stands in for the tristate state of a shared data bus. Storage is split into two banks by word-address bit 0, and each bank has one registered read port and one byte-enabled write port. Write beats pass through one capture register before they reach the array. A compare against that register forwards fresh bytes to a read that follows at once.

Top module: `ddr_burst4_sram`

## Requirements
- R1: A load accepted at clock edge t makes a burst of exactly four words that occupies the two following cycles, t+1 and t+2.
- R2: `ld_n` (active low), `rd_wr_n` and `addr` are sampled on the rising clock edge. `rd_wr_n` = 1 selects a read and `rd_wr_n` = 0 selects a write.
- R3: Word k (k = 0..3) of a burst with start address a goes to address {a[AW-1:2], (a[1:0]+k) mod 4}. For example, start offset 3 gives the order 3, 0, 1, 2.
- R4: While the first cycle of a burst is running (t+1), `ld_n`, `rd_wr_n` and `addr` are ignored.
- R5: For a write loaded at edge t, words 0 and 1 are taken from `wd_k` and `wd_kb` at edge t+1, and words 2 and 3 are taken from the same lanes at edge t+2.
- R6: For a read loaded at edge t, these values are valid after each edge: after t+1, `rq_cb` = word 0; after t+2, `rq_c` = word 1 and `rq_cb` = word 2; after t+3, `rq_c` = word 3.
- R7: Bit j of `bw_k_n` / `bw_kb_n` controls data bits [j*9+8 : j*9] of the beat on the same lane (9-bit bytes by default). The byte is written when the bit is 0 and kept when it is 1. Both bits at 1 write nothing.
- R8: While `rst` is high, and after it, `oe_cb` and `oe_c` are 0. Each lane's enable is high only in the cycles that R6 gives it read data. A lane whose enable is low drives zero data.
- R9: A read loaded straight after a write burst (two cycles apart) to the same address returns the newly merged data.
- R10: A new load is accepted in the second cycle of a running burst, so bursts can follow back to back with one load every two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one period per bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low burst load strobe |
| rd_wr_n | input | 1 | Direction of the loaded burst: 1 read, 0 write |
| addr | input | AW | Word address of the first word of the burst |
| wd_k | input | W | Write beat on the first half of the cycle |
| wd_kb | input | W | Write beat on the second half of the cycle |
| bw_k_n | input | NB | Active-low byte enables for `wd_k` |
| bw_kb_n | input | NB | Active-low byte enables for `wd_kb` |
| rq_cb | output | W | Read lane for words 0 and 2 |
| rq_c | output | W | Read lane for words 1 and 3 |
| oe_cb | output | 1 | Drive enable for `rq_cb` |
| oe_c | output | 1 | Drive enable for `rq_c` |

## Verification
The assertions assume that reset is held for at least one edge before the first load, and that `ld_n`, `rd_wr_n` and the address are always 0 or 1, never unknown. The stimulus keeps to this. It applies reset first and drives every input at the falling edge with defined values, including random but legal values during the ignored first burst cycle. It then fills the whole array once before the random phase, so every read finds known contents.

// File: rtl/ddr4b_pkg.sv
package ddr4b_pkg;

  // Bus cycle position of the burst sequencer
  typedef enum logic [1:0] {
    PH_NOP  = 2'd0,
    PH_HEAD = 2'd1,
    PH_TAIL = 2'd2
  } phase_t;

  // Linear wrap inside an aligned group of four words
  function automatic logic [1:0] wrap_off(input logic [1:0] start, input logic [1:0] step);
    return start + step;
  endfunction

endpackage

// File: rtl/ddr4b_seq.sv
module ddr4b_seq
  import ddr4b_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_n,
  input  logic                 rd_wr_n,
  input  logic [AW-1:0]        addr,
  output phase_t               phase,
  output logic                 op_rd,
  output logic [AW-3:0]        base,
  output logic                 lo_bank,
  output logic [1:0][AW-2:0]   rows
);

  logic [1:0] start;
  logic [1:0] off0;
  logic [1:0] off1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_NOP;
      op_rd <= 1'b0;
      base  <= '0;
      start <= '0;
    end else begin
      case (phase)
        PH_HEAD: phase <= PH_TAIL;
        default: begin
          if (!ld_n) begin
            phase <= PH_HEAD;
            op_rd <= rd_wr_n;
            base  <= addr[AW-1:2];
            start <= addr[1:0];
          end else begin
            phase <= PH_NOP;
          end
        end
      endcase
    end
  end

  // Pair of words handled this cycle: offsets 0/1 in the head, 2/3 in the tail
  assign off0    = wrap_off(start, (phase == PH_TAIL) ? 2'd2 : 2'd0);
  assign off1    = wrap_off(off0, 2'd1);
  assign lo_bank = off0[0];

  always_comb begin
    rows[0] = {base, (off0[0] ? off1[1] : off0[1])};
    rows[1] = {base, (off0[0] ? off0[1] : off1[1])};
  end

endmodule

// File: rtl/ddr4b_wstage.sv
module ddr4b_wstage #(
  parameter int AW = 8,
  parameter int W  = 18,
  parameter int NB = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic                 lo_bank,
  input  logic [1:0][AW-2:0]   rows,
  input  logic [W-1:0]         wd_k,
  input  logic [W-1:0]         wd_kb,
  input  logic [NB-1:0]        bw_k_n,
  input  logic [NB-1:0]        bw_kb_n,
  output logic                 st_v,
  output logic [1:0][AW-2:0]   st_row,
  output logic [1:0][W-1:0]    st_dat,
  output logic [1:0][NB-1:0]   st_be
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v <= 1'b0;
    end else begin
      st_v <= cap;
    end
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (cap) begin
          st_row[b] <= rows[b];
          if (lo_bank == b[0]) begin
            st_dat[b] <= wd_k;
            st_be[b]  <= ~bw_k_n;
          end else begin
            st_dat[b] <= wd_kb;
            st_be[b]  <= ~bw_kb_n;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ddr4b_bank.sv
module ddr4b_bank #(
  parameter int RAW = 7,
  parameter int W   = 18,
  parameter int NB  = 2
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RAW-1:0]  wrow,
  input  logic [W-1:0]    wdat,
  input  logic [NB-1:0]   wbe,
  input  logic            re,
  input  logic [RAW-1:0]  rrow,
  output logic [W-1:0]    rdat
);

  localparam int DEPTH = 1 << RAW;
  localparam int BW    = W / NB;

  generate
    for (genvar j = 0; j < NB; j++) begin : g_lane
      logic [BW-1:0] arr [DEPTH];
      logic [BW-1:0] q;

      always_ff @(posedge clk) begin
        if (we && wbe[j]) begin
          arr[wrow] <= wdat[j*BW +: BW];
        end
        if (re) begin
          q <= arr[rrow];
        end
      end

      assign rdat[j*BW +: BW] = q;
    end
  endgenerate

endmodule

// File: rtl/ddr4b_rpath.sv
module ddr4b_rpath #(
  parameter int AW = 8,
  parameter int W  = 18,
  parameter int NB = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic                 lo_bank,
  input  logic [1:0][AW-2:0]   rows,
  input  logic                 st_v,
  input  logic [1:0][AW-2:0]   st_row,
  input  logic [1:0][W-1:0]    st_dat,
  input  logic [1:0][NB-1:0]   st_be,
  input  logic [1:0][W-1:0]    mem_q,
  output logic [W-1:0]         rq_cb,
  output logic [W-1:0]         rq_c,
  output logic                 oe_cb,
  output logic                 oe_c
);

  localparam int BW = W / NB;

  logic                rv;
  logic                sel;
  logic [1:0]          hit;
  logic [1:0][W-1:0]   bdat;
  logic [1:0][NB-1:0]  bbe;
  logic [1:0][W-1:0]   merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv   <= 1'b0;
      sel  <= 1'b0;
      hit  <= '0;
      oe_c <= 1'b0;
      rq_c <= '0;
    end else begin
      rv   <= issue;
      sel  <= lo_bank;
      oe_c <= rv;
      rq_c <= rv ? merged[~sel] : '0;
      for (int b = 0; b < 2; b++) begin
        hit[b] <= issue && st_v && (st_row[b] == rows[b]);
      end
    end
  end

  // Bytes being written in the same edge as the read are forwarded
  always_ff @(posedge clk) begin
    if (issue) begin
      bdat <= st_dat;
      bbe  <= st_be;
    end
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_mrg
      for (genvar j = 0; j < NB; j++) begin : g_byte
        assign merged[b][j*BW +: BW] = (hit[b] && bbe[b][j]) ? bdat[b][j*BW +: BW]
                                                              : mem_q[b][j*BW +: BW];
      end
    end
  endgenerate

  assign oe_cb = rv;
  assign rq_cb = rv ? merged[sel] : '0;

endmodule

// File: rtl/ddr_burst4_sram.sv
module ddr_burst4_sram
  import ddr4b_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 18,
  parameter int NB = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_n,
  input  logic           rd_wr_n,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wd_k,
  input  logic [W-1:0]   wd_kb,
  input  logic [NB-1:0]  bw_k_n,
  input  logic [NB-1:0]  bw_kb_n,
  output logic [W-1:0]   rq_cb,
  output logic [W-1:0]   rq_c,
  output logic           oe_cb,
  output logic           oe_c
);

  localparam int RAW = AW - 1;

  phase_t              phase;
  logic                op_rd;
  logic [AW-3:0]       base;
  logic                lo_bank;
  logic [1:0][RAW-1:0] rows;
  logic                active;
  logic                st_v;
  logic [1:0][RAW-1:0] st_row;
  logic [1:0][W-1:0]   st_dat;
  logic [1:0][NB-1:0]  st_be;
  logic [1:0][W-1:0]   mem_q;

  ddr4b_seq #(.AW(AW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .ld_n    (ld_n),
    .rd_wr_n (rd_wr_n),
    .addr    (addr),
    .phase   (phase),
    .op_rd   (op_rd),
    .base    (base),
    .lo_bank (lo_bank),
    .rows    (rows)
  );

  assign active = (phase != PH_NOP);

  ddr4b_wstage #(.AW(AW), .W(W), .NB(NB)) u_wst (
    .clk     (clk),
    .rst     (rst),
    .cap     (active && !op_rd),
    .lo_bank (lo_bank),
    .rows    (rows),
    .wd_k    (wd_k),
    .wd_kb   (wd_kb),
    .bw_k_n  (bw_k_n),
    .bw_kb_n (bw_kb_n),
    .st_v    (st_v),
    .st_row  (st_row),
    .st_dat  (st_dat),
    .st_be   (st_be)
  );

  generate
    for (genvar b = 0; b < 2; b++) begin : g_mem
      ddr4b_bank #(.RAW(RAW), .W(W), .NB(NB)) u_bank (
        .clk  (clk),
        .we   (st_v),
        .wrow (st_row[b]),
        .wdat (st_dat[b]),
        .wbe  (st_be[b]),
        .re   (active && op_rd),
        .rrow (rows[b]),
        .rdat (mem_q[b])
      );
    end
  endgenerate

  ddr4b_rpath #(.AW(AW), .W(W), .NB(NB)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .issue   (active && op_rd),
    .lo_bank (lo_bank),
    .rows    (rows),
    .st_v    (st_v),
    .st_row  (st_row),
    .st_dat  (st_dat),
    .st_be   (st_be),
    .mem_q   (mem_q),
    .rq_cb   (rq_cb),
    .rq_c    (rq_c),
    .oe_cb   (oe_cb),
    .oe_c    (oe_c)
  );

endmodule

// File: rtl/ddr_burst4_sram_chk.sv
module ddr_burst4_sram_chk
  import ddr4b_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_n,
  input  phase_t         phase,
  input  logic           op_rd,
  input  logic [AW-3:0]  base,
  input  logic           oe_cb,
  input  logic           oe_c
);

  logic rst_q;

  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_QUIET: assert (!oe_cb && !oe_c); // R8
    end
  end

  AST_TWO_CYCLE_BURST: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HEAD) |=> (phase == PH_TAIL)); // R1

  AST_HEAD_IGNORES_LOAD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HEAD) |=> ($stable(base) && $stable(op_rd))); // R4

  AST_LOAD_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    ((phase != PH_HEAD) && !ld_n) |=> (phase == PH_HEAD)); // R10

  AST_READ_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_HEAD) && op_rd) |=> oe_cb); // R6

  AST_READ_MID_WORDS: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_TAIL) && op_rd) |=> (oe_cb && oe_c)); // R6

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_HEAD) && !op_rd) |=> !oe_cb); // R8

  AST_NOP_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NOP) |=> !oe_cb); // R8

endmodule

bind ddr_burst4_sram ddr_burst4_sram_chk #(.AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .ld_n  (ld_n),
  .phase (phase),
  .op_rd (op_rd),
  .base  (base),
  .oe_cb (oe_cb),
  .oe_c  (oe_c)
);

// File: tb/test_ddr_burst4_sram.sv
`timescale 1ns/1ps
module test_ddr_burst4_sram;

  localparam int AW = 8;
  localparam int W  = 18;
  localparam int NB = 2;
  localparam int BW = W / NB;

  logic           clk = 1'b0;
  logic           rst;
  logic           ld_n;
  logic           rd_wr_n;
  logic [AW-1:0]  addr;
  logic [W-1:0]   wd_k;
  logic [W-1:0]   wd_kb;
  logic [NB-1:0]  bw_k_n;
  logic [NB-1:0]  bw_kb_n;
  logic [W-1:0]   rq_cb;
  logic [W-1:0]   rq_c;
  logic           oe_cb;
  logic           oe_c;

  always #2.5 clk = ~clk;

  ddr_burst4_sram #(.AW(AW), .W(W), .NB(NB)) i_ddr_burst4_sram (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rd_wr_n(rd_wr_n), .addr(addr),
    .wd_k(wd_k), .wd_kb(wd_kb), .bw_k_n(bw_k_n), .bw_kb_n(bw_kb_n),
    .rq_cb(rq_cb), .rq_c(rq_c), .oe_cb(oe_cb), .oe_c(oe_c)
  );

  int nchk = 0;
  int nerr = 0;
  int ecnt = 0;
  string tag = "R8";

  logic [W-1:0] refm [1 << AW];
  logic         e_cbv [8];
  logic [W-1:0] e_cb  [8];
  logic         e_cv  [8];
  logic [W-1:0] e_c   [8];

  // lanes queued for the next cycle
  logic [W-1:0]  n_k, n_kb;
  logic [NB-1:0] n_mk, n_mkb;

  always @(posedge clk) ecnt <= ecnt + 1;

  task automatic check(input string rq, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Compare outputs against the slot of the edge just taken (R6, R8)
  task automatic check_slots();
    int s = ecnt % 8;
    check("R8", "oe_cb", W'(oe_cb), W'(e_cbv[s]));
    check(e_cbv[s] ? tag : "R8", "rq_cb", rq_cb, e_cbv[s] ? e_cb[s] : '0);
    check("R8", "oe_c", W'(oe_c), W'(e_cv[s]));
    check(e_cv[s] ? tag : "R8", "rq_c", rq_c, e_cv[s] ? e_c[s] : '0);
    e_cbv[s] = 1'b0;
    e_cv[s]  = 1'b0;
  endtask

  task automatic junk_next();
    n_k = W'($urandom); n_kb = W'($urandom);
    n_mk = NB'($urandom); n_mkb = NB'($urandom);
  endtask

  task automatic drive_lanes();
    wd_k = n_k; wd_kb = n_kb; bw_k_n = n_mk; bw_kb_n = n_mkb;
  endtask

  task automatic idle();
    @(negedge clk);
    check_slots();
    ld_n = 1'b1; rd_wr_n = 1'($urandom); addr = AW'($urandom);
    drive_lanes();
    junk_next();
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  // rd: 1 read, 0 write; part: random byte enables on writes (R7)
  task automatic burst(input bit rd, input logic [AW-1:0] a, input bit part);
    logic [W-1:0]  d [4];
    logic [NB-1:0] m [4];
    int n;
    for (int k = 0; k < 4; k++) begin
      d[k] = W'($urandom);
      m[k] = part ? NB'($urandom) : '0;
      if (!rd) begin
        for (int j = 0; j < NB; j++) begin
          if (!m[k][j]) refm[beat_addr(a, k)][j*BW +: BW] = d[k][j*BW +: BW];
        end
      end
    end
    // load cycle (R2)
    @(negedge clk);
    check_slots();
    ld_n = 1'b0; rd_wr_n = rd; addr = a;
    drive_lanes();
    n = ecnt + 1;
    if (rd) begin
      e_cbv[(n+1)%8] = 1'b1; e_cb[(n+1)%8] = refm[beat_addr(a, 0)];
      e_cv[(n+2)%8]  = 1'b1; e_c[(n+2)%8]  = refm[beat_addr(a, 1)];
      e_cbv[(n+2)%8] = 1'b1; e_cb[(n+2)%8] = refm[beat_addr(a, 2)];
      e_cv[(n+3)%8]  = 1'b1; e_c[(n+3)%8]  = refm[beat_addr(a, 3)];
      junk_next();
    end else begin
      n_k = d[0]; n_mk = m[0]; n_kb = d[1]; n_mkb = m[1];
    end
    // first burst cycle: load strobe and address must be ignored (R4)
    @(negedge clk);
    check_slots();
    ld_n = 1'($urandom); rd_wr_n = 1'($urandom); addr = AW'($urandom);
    drive_lanes();
    if (rd) junk_next();
    else begin
      n_k = d[2]; n_mk = m[2]; n_kb = d[3]; n_mkb = m[3];
    end
  endtask

  initial begin
    #750000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < 8; s++) begin e_cbv[s] = 1'b0; e_cv[s] = 1'b0; end
    rst = 1'b1; ld_n = 1'b1; rd_wr_n = 1'b1; addr = '0;
    junk_next(); drive_lanes();
    // R8: reset state
    repeat (3) begin @(negedge clk); check_slots(); end
    rst = 1'b0;
    idle(); idle();

    // Fill the array with full-width back-to-back writes (R5, R10)
    tag = "R5";
    for (int i = 0; i < (1 << AW) / 4; i++) burst(1'b0, AW'(i * 4), 1'b0);
    idle();

    // R3: every start offset, write then read with gaps
    tag = "R3";
    for (int o = 0; o < 4; o++) begin
      burst(1'b0, AW'(8'h50 + o), 1'b0);
      idle();
      burst(1'b1, AW'(8'h50 + o), 1'b0);
      idle(); idle(); idle();
    end

    // R7: partial byte enables, including all-high beats
    tag = "R7";
    for (int i = 0; i < 6; i++) begin
      burst(1'b0, AW'(8'h20 + i), 1'b1);
      idle();
      burst(1'b1, AW'(8'h20 + i), 1'b0);
      idle(); idle();
    end

    // R10: back-to-back reads
    tag = "R10";
    burst(1'b1, 8'h03, 1'b0); burst(1'b1, 8'h41, 1'b0); burst(1'b1, 8'h92, 1'b0);
    idle(); idle(); idle();

    // R9: read directly after a masked write to the same address
    tag = "R9";
    for (int o = 0; o < 4; o++) begin
      burst(1'b0, AW'(8'h71 + o), 1'b1);
      burst(1'b1, AW'(8'h71 + o), 1'b0);
    end
    idle(); idle(); idle();

    // R6: mixed random traffic over a narrow window to provoke forwarding
    tag = "R6";
    for (int i = 0; i < 400; i++) begin
      burst(1'($urandom), AW'($urandom_range(0, 31)), 1'($urandom));
      if ($urandom_range(0, 3) == 0) idle();
    end
    repeat (5) idle();

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule